// File: doc/BRIEF.md
# Comparator-Driven Offset Calibration Integrator

A differential analog front end carries a DC offset referred to its input. This block is the digital half of the loop that cancels it. A clocked comparator samples the front-end output once per cycle of a sampling clock. That clock may be unrelated to the data rate, because offset is a DC quantity. The engine integrates each one-bit decision in a signed up/down accumulator. The most significant bits of the accumulator drive a correction DAC, which subtracts a DC term at the front-end input.

The unused low bits of the accumulator act as a filter. A noisy decision moves the DAC code only after it has been repeated many times. The loop polarity is degenerative: a high decision raises the correction, so the residual offset shrinks. To calibrate, hold the differential input at 0 V and assert the enable shortly after reset. Then wait for the settled flag before freezing the code by dropping the enable.

Top module: `offset_cal_engine`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to zero. After the reset edge, `dac_code` reads 0 (mid-scale) and `settled` reads 0.
- R2: `dac_code` is the top CODE_W bits of the ACC_W-bit two's-complement accumulator. With the defaults (10 and 6) it equals the accumulator value divided by 16, rounded toward minus infinity, and it is valid in the cycle after the clock edge that updates the accumulator.
- R3: While `cal_en` is 0, the accumulator holds its value, whatever `cmp_hi` does.
- R4: On each clock edge with `cal_en` at 1, the accumulator rises by one when `cmp_hi` is 1 and falls by one when `cmp_hi` is 0.
- R5: The accumulator saturates at +(2^(ACC_W-1)-1) and at -2^(ACC_W-1) and never wraps. With the defaults, `dac_code` stops at +31 and at -32.
- R6: The settle monitor keeps a reference code. On each enabled edge, if `dac_code` is within ±1 of the reference, a run counter advances. Otherwise, and on every edge with `cal_en` at 0, the reference takes the current code and the run is cleared. `settled` goes to 1 after the edge that completes SETTLE_CYCLES consecutive in-window edges. It drops after any edge that breaks the run or sees `cal_en` at 0.
- R7: In a closed loop where the comparator reports 1 whenever the offset (in DAC LSBs) exceeds `dac_code`, the code converges to within ±1 of the offset and `settled` asserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock shared with the comparator |
| rst | input | 1 | Synchronous active-high reset |
| cal_en | input | 1 | Calibration enable; accumulator frozen when low |
| cmp_hi | input | 1 | Comparator decision for this cycle |
| dac_code | output | CODE_W | Signed correction code for the offset DAC |
| settled | output | 1 | Code has stayed within ±1 LSB for SETTLE_CYCLES clocks |

## Verification
The assertions assume that `cal_en` and `cmp_hi` are clean, single-bit, synchronous levels that change only away from the sampling edge. They also assume that reset is held for at least one edge before any property is judged. The bench drives every input on the falling edge, so each rising edge sees settled values. Its random phase draws only legal levels for enable and decision. Saturation and the settle window are reached by directed runs that push the accumulator hard against each rail and then dither around a fixed code.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_UP   = 2'd1,
    ACC_DOWN = 2'd2
  } acc_op_e;

  // True when two signed codes differ by at most one step.
  function automatic logic near_one(input int a, input int b);
    int d;
    d = a - b;
    return (d >= -1) && (d <= 1);
  endfunction

endpackage

// File: rtl/ocal_accum.sv
module ocal_accum
  import ocal_pkg::*;
#(
  parameter int ACC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  acc_op_e                 op,
  output logic signed [ACC_W-1:0] acc_q
);
  localparam logic signed [ACC_W-1:0] TOP = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] BOT = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

  logic signed [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    case (op)
      ACC_UP:   if (acc_q != TOP) acc_d = acc_q + ONE;
      ACC_DOWN: if (acc_q != BOT) acc_d = acc_q - ONE;
      default:  acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end
endmodule

// File: rtl/ocal_settle.sv
module ocal_settle
  import ocal_pkg::*;
#(
  parameter int CODE_W        = 6,
  parameter int SETTLE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic              settled_q
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(SETTLE_CYCLES);
  localparam logic [CW-1:0] RUN_END = CW'(SETTLE_CYCLES - 1);

  logic [CODE_W-1:0] ref_q;
  logic [CW-1:0]     run_q;
  logic              in_win;

  always_comb begin
    in_win = near_one(int'($signed(code)), int'($signed(ref_q)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= '0;
      run_q     <= '0;
      settled_q <= 1'b0;
    end else if (!en || !in_win) begin
      ref_q     <= code;
      run_q     <= '0;
      settled_q <= 1'b0;
    end else begin
      run_q     <= (run_q == RUN_MAX) ? RUN_MAX : run_q + CW'(1);
      settled_q <= (run_q >= RUN_END);
    end
  end
endmodule

// File: rtl/offset_cal_engine.sv
module offset_cal_engine
  import ocal_pkg::*;
#(
  parameter int ACC_W         = 10,
  parameter int CODE_W        = 6,
  parameter int SETTLE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_en,
  input  logic              cmp_hi,
  output logic [CODE_W-1:0] dac_code,
  output logic              settled
);
  localparam int DROP = ACC_W - CODE_W;

  acc_op_e                 op;
  logic signed [ACC_W-1:0] acc_q;

  // Degenerative polarity: a high decision raises the correction.
  always_comb begin
    if (!cal_en)     op = ACC_HOLD;
    else if (cmp_hi) op = ACC_UP;
    else             op = ACC_DOWN;
  end

  ocal_accum #(.ACC_W(ACC_W)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .acc_q (acc_q)
  );

  // Code is taken straight from accumulator flops: registered, no extra stage.
  assign dac_code = acc_q[ACC_W-1 -: CODE_W];

  ocal_settle #(.CODE_W(CODE_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk       (clk),
    .rst       (rst),
    .en        (cal_en),
    .code      (dac_code),
    .settled_q (settled)
  );

  logic unused_low;
  assign unused_low = ^acc_q[DROP-1:0];
endmodule

// File: rtl/ocal_checker.sv
module ocal_checker #(
  parameter int ACC_W  = 10,
  parameter int CODE_W = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cal_en,
  input logic                    cmp_hi,
  input logic signed [ACC_W-1:0] acc,
  input logic [CODE_W-1:0]       dac_code,
  input logic                    settled
);
  localparam logic signed [ACC_W-1:0] TOP = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] BOT = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

  p_reset_r1: assert property (@(posedge clk) rst |=> (acc == '0) && !settled);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    cal_en |=> (($signed({dac_code[CODE_W-1], dac_code}) -
                 $past($signed({dac_code[CODE_W-1], dac_code}))) inside {-1, 0, 1}));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cal_en |=> $stable(acc));

  p_up_r4: assert property (@(posedge clk) disable iff (rst)
    cal_en && cmp_hi && (acc != TOP) |=> (acc - $past(acc)) == ONE);

  p_down_r4: assert property (@(posedge clk) disable iff (rst)
    cal_en && !cmp_hi && (acc != BOT) |=> ($past(acc) - acc) == ONE);

  p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
    cal_en && cmp_hi && (acc == TOP) |=> acc == TOP);

  p_sat_bot_r5: assert property (@(posedge clk) disable iff (rst)
    cal_en && !cmp_hi && (acc == BOT) |=> acc == BOT);

  p_settle_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !cal_en |=> !settled);
endmodule

bind offset_cal_engine ocal_checker #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cal_en   (cal_en),
  .cmp_hi   (cmp_hi),
  .acc      (acc_q),
  .dac_code (dac_code),
  .settled  (settled)
);

// File: tb/sim_offset_cal_engine.sv
module sim_offset_cal_engine;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N = 10;
  localparam int M = 6;
  localparam int K = 32;
  localparam int SH = N - M;
  localparam int AMAX = (1 << (N - 1)) - 1;
  localparam int AMIN = -(1 << (N - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_en = 1'b0;
  logic cmp_hi = 1'b0;
  logic [M-1:0] dac_code;
  logic settled;

  always #2.5 clk = ~clk;

  offset_cal_engine #(.ACC_W(N), .CODE_W(M), .SETTLE_CYCLES(K)) u0 (
    .clk(clk), .rst(rst), .cal_en(cal_en), .cmp_hi(cmp_hi),
    .dac_code(dac_code), .settled(settled)
  );

  int checks = 0;
  int errors = 0;
  int m_acc = 0, m_ref = 0, m_run = 0;
  bit m_set = 0;
  bit finished = 0;

  function automatic int code_of(int a);
    return a >>> SH;
  endfunction

  function automatic int next_acc(int a, bit en, bit c);
    if (!en) return a;
    if (c)   return (a == AMAX) ? a : a + 1;
    return (a == AMIN) ? a : a - 1;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: drive at falling edge, model the rising edge, sample at next falling edge.
  task automatic step(bit r, bit en, bit c);
    int cd;
    rst = r; cal_en = en; cmp_hi = c;
    @(posedge clk);
    cd = code_of(m_acc);
    if (r) begin
      m_acc = 0; m_ref = 0; m_run = 0; m_set = 0;
    end else begin
      if (!en || (cd - m_ref > 1) || (cd - m_ref < -1)) begin
        m_ref = cd; m_run = 0; m_set = 0;
      end else begin
        m_set = (m_run >= K - 1);
        m_run = (m_run == K) ? K : m_run + 1;
      end
      m_acc = next_acc(m_acc, en, c);
    end
    @(negedge clk);
    chk("R2/R4 code", int'($signed(dac_code)), code_of(m_acc));
    chk("R6 settled", int'(settled), int'(m_set));
  endtask

  task automatic loop_run(int offs, int cycles);
    for (int i = 0; i < cycles; i++)
      step(1'b0, 1'b1, offs > int'($signed(dac_code)));
  endtask

  initial begin : wd
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (finished) disable wd;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int held;
    void'($urandom(32'h5EED_0C41));
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
    // R1 reset state
    chk("R1 code after reset", int'($signed(dac_code)), 0);
    chk("R1 settled after reset", int'(settled), 0);

    // R4 count up 16 -> R2 code 1
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b1);
    chk("R2 code after 16 ups", int'($signed(dac_code)), 1);
    for (int i = 0; i < 48; i++) step(1'b0, 1'b1, 1'b0);
    chk("R4 code after 32 net downs", int'($signed(dac_code)), -2);

    // R3 hold with enable low
    held = int'($signed(dac_code));
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'($urandom_range(0, 1)));
    chk("R3 code held", int'($signed(dac_code)), held);

    // R5 saturation at both rails
    for (int i = 0; i < 700; i++) step(1'b0, 1'b1, 1'b1);
    chk("R5 top rail code", int'($signed(dac_code)), 31);
    for (int i = 0; i < 1100; i++) step(1'b0, 1'b1, 1'b0);
    chk("R5 bottom rail code", int'($signed(dac_code)), -32);

    // R6 settle window: dither on the bottom rail, then drop enable
    step(1'b0, 1'b0, 1'b0);
    chk("R6 cleared by enable low", int'(settled), 0);
    for (int i = 0; i < K; i++) step(1'b0, 1'b1, 1'(i & 1));
    chk("R6 set after K in-window edges", int'(settled), 1);
    step(1'b0, 1'b0, 1'b1);
    chk("R6 dropped with enable low", int'(settled), 0);

    // Random phase, including mid-run reset (R1)
    for (int i = 0; i < 3000; i++) begin
      bit rr;
      rr = ($urandom_range(0, 499) == 0);
      step(rr, ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));
    end
    step(1'b1, 1'b1, 1'b1);
    chk("R1 code after mid-run reset", int'($signed(dac_code)), 0);

    // R7 closed loop, positive then negative offset
    loop_run(10, 600);
    chk("R7 converged +10", int'(int'($signed(dac_code)) >= 9 && int'($signed(dac_code)) <= 11), 1);
    chk("R7 settled +10", int'(settled), 1);
    step(1'b1, 1'b0, 1'b0);
    loop_run(-7, 600);
    chk("R7 converged -7", int'(int'($signed(dac_code)) >= -8 && int'($signed(dac_code)) <= -6), 1);
    chk("R7 settled -7", int'(settled), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule